// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block runs one logic-analyser acquisition against an external circular sample memory. An arm pulse latches the three programmed values: a read count, a delay count and a six-bit flag word. Each valid input sample then has the bytes of its enabled channel groups packed into 32-bit memory words, and these are written at consecutive addresses that wrap at the end of the memory. The trigger pulse is accepted at any point of the pre-trigger phase. After it, the block stores the programmed number of post-trigger units, stops writing, and reads back the most recent units from the oldest one forward. The bytes of the enabled groups leave the block one per cycle on a byte stream.

Both counts are programmed as the wanted number minus one. They are measured in units of four samples, or eight samples when the demux flag is set. The read count gives the total length of the readback. The delay count gives the post-trigger share, and the difference between the two is the pre-trigger share. An abort input cancels a capture or a readback at any time and returns the block to idle.

Top module: `capture_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `mem_we`, `mem_re`, `rb_valid` and `rb_last` are low, and they stay low until an arm pulse is followed by a trigger.
- R2: The readback carries exactly (read_cnt+1) units of samples. A unit is 4 samples, or 8 samples when flag bit 0 (demux) is 1.
- R3: Writing stops at the (delay_cnt+1)-th unit boundary counted from the trigger cycle (a unit that completes in the trigger cycle counts). Samples that arrive after that are not written, and a trigger outside the capture phase has no effect.
- R4: The readback begins at the oldest of the last (read_cnt+1) stored units and runs in storage order, wrapping through the top address of the memory.
- R5: Flag bits 5:2 disable byte groups 3:0, with bit 2 for group 0 (bits [7:0] of `smp_data`). A 1 means the group is not captured. For each sample the readback carries only the enabled groups' bytes, lowest group first.
- R6: A memory word holds four samples when one group is enabled, two samples when two are enabled, and one sample when three or four are enabled. With three groups the top byte is padded and is not sent back.
- R7: When the demux flag is 1, the effective disables of groups 3 and 2 are copied from flag bits 3 and 2, and flag bits 5 and 4 are ignored.
- R8: A trigger that comes before the pre-trigger share has been stored is taken at once. The readback keeps its full length, and its leading units are the stale memory words below the first write.
- R9: An abort stops writing and reading from the next cycle, with no further readback, and a later arm starts a normal capture.
- R10: An arm pulse while all four groups are effectively disabled is ignored: nothing is written and nothing is read back.
- R11: Each memory read is a single-cycle `mem_re` pulse whose data is taken on the next cycle. `rb_last` marks the final byte of the readback, and `mem_re` is never high in a cycle that sends a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Starts a capture when idle and latches the settings |
| abort | input | 1 | Cancels the current capture or readback |
| read_cnt | input | CW | Total readback units minus one |
| delay_cnt | input | CW | Post-trigger units minus one |
| flags | input | 6 | Bit 0 demux, bits 5:2 group disables, bit 1 unused |
| trig | input | 1 | Trigger pulse |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Sample, four 8-bit groups |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | 32 | Memory write word |
| mem_re | output | 1 | Memory read request |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_re` |
| rb_valid | output | 1 | Readback byte valid |
| rb_byte | output | 8 | Readback byte |
| rb_last | output | 1 | Final readback byte |

## Verification
A wrong write pointer or packing slot changes the byte stream at the first unit it touches. That shows up in the readback order or content as soon as that unit is sent, and in the number of memory writes once the capture ends. A wrong post-trigger counter moves the end of the capture by whole units, so the write count and the readback window shift by a multiple of four or eight samples. A stuck read sequencer shows at once: `mem_re` and `rb_valid` overlap, or `rb_last` never arrives. The stimulus covers every packing density, the demux mirror, a wrapping write pointer, an early trigger, an abort and an all-disabled arm.

// File: rtl/capseq_pkg.sv
package capseq_pkg;
  localparam int GRP_N     = 4;
  localparam int GRP_W     = 8;
  localparam int WORD_W    = GRP_N * GRP_W;
  localparam int FLAG_W    = 6;
  localparam int DEMUX_BIT = 0;
  localparam int DIS_LSB   = 2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_POST,
    SQ_RREQ,
    SQ_RWAIT,
    SQ_EMIT
  } seq_state_e;

  // blog: log2 of stored bytes per sample; wlog: log2 of words per unit
  typedef struct packed {
    logic [GRP_N-1:0] en;
    logic [1:0]       blog;
    logic [1:0]       wlog;
    logic [2:0]       nemit;
  } grp_cfg_t;
endpackage

// File: rtl/capseq_grp_decode.sv
module capseq_grp_decode
  import capseq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  output grp_cfg_t          cfg,
  output logic              none_on
);
  localparam int HALF = GRP_N / 2;

  logic [GRP_N-1:0] dis;
  logic [2:0]       n_on;
  logic             demux;
  logic             unused_flag_bit;

  assign demux           = flags[DEMUX_BIT];
  assign unused_flag_bit = flags[1];

  always_comb begin
    dis = flags[DIS_LSB +: GRP_N];
    if (demux) begin
      for (int g = HALF; g < GRP_N; g++) dis[g] = dis[g-HALF];
    end
  end

  assign n_on = 3'($countones(~dis));

  always_comb begin
    cfg.en = ~dis;
    case (n_on)
      3'd1:    cfg.blog = 2'd0;
      3'd2:    cfg.blog = 2'd1;
      default: cfg.blog = 2'd2;
    endcase
    cfg.wlog  = cfg.blog + {1'b0, demux};
    cfg.nemit = (n_on == 3'd3) ? 3'd3 : 3'd4;
  end

  assign none_on = (n_on == 3'd0);
endmodule

// File: rtl/capseq_packer.sv
module capseq_packer
  import capseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [WORD_W-1:0] data,
  input  grp_cfg_t          cfg,
  output logic              fire,
  output logic              unit_done,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] acc_q, acc_d, comp, merged;
  logic [1:0]        slot_q, slot_d;
  logic [2:0]        wiu_q, wiu_d;
  logic [2:0]        slots;
  logic [3:0]        wpu;
  logic              last_slot, last_word;

  // compact enabled groups, lowest first
  always_comb begin
    int k;
    comp = '0;
    k = 0;
    for (int g = 0; g < GRP_N; g++) begin
      if (cfg.en[g]) begin
        comp[k*GRP_W +: GRP_W] = data[g*GRP_W +: GRP_W];
        k = k + 1;
      end
    end
  end

  // drop the compacted sample into its slot
  always_comb begin
    int nb, base;
    nb = 1 << cfg.blog;
    base = int'(slot_q) * nb;
    merged = acc_q;
    for (int b = 0; b < GRP_N; b++) begin
      if (b >= base && b < base + nb)
        merged[b*GRP_W +: GRP_W] = comp[(b-base)*GRP_W +: GRP_W];
    end
  end

  assign slots     = 3'd4 >> cfg.blog;
  assign wpu       = 4'd1 << cfg.wlog;
  assign last_slot = ({1'b0, slot_q} == slots - 3'd1);
  assign last_word = ({1'b0, wiu_q} == wpu - 4'd1);
  assign fire      = take && last_slot;
  assign unit_done = fire && last_word;
  assign word      = merged;

  always_comb begin
    acc_d  = acc_q;
    slot_d = slot_q;
    wiu_d  = wiu_q;
    if (clr) begin
      acc_d  = '0;
      slot_d = '0;
      wiu_d  = '0;
    end else if (take) begin
      if (last_slot) begin
        acc_d  = '0;
        slot_d = '0;
        wiu_d  = last_word ? 3'd0 : wiu_q + 3'd1;
      end else begin
        acc_d  = merged;
        slot_d = slot_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
      wiu_q  <= '0;
    end else begin
      acc_q  <= acc_d;
      slot_q <= slot_d;
      wiu_q  <= wiu_d;
    end
  end
endmodule

// File: rtl/capseq_byte_out.sv
module capseq_byte_out
  import capseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              last_word,
  input  logic [2:0]        nemit,
  output logic              rb_valid,
  output logic [GRP_W-1:0]  rb_byte,
  output logic              rb_last,
  output logic              word_done
);
  logic [WORD_W-1:0] hold_q;
  logic [1:0]        idx_q;
  logic              act_q, lastw_q;
  logic              end_byte;

  assign end_byte  = act_q && ({1'b0, idx_q} == nemit - 3'd1);
  assign rb_valid  = act_q;
  assign rb_byte   = hold_q[{idx_q, 3'b000} +: GRP_W];
  assign rb_last   = end_byte && lastw_q;
  assign word_done = end_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      idx_q   <= '0;
      act_q   <= 1'b0;
      lastw_q <= 1'b0;
    end else if (clr) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (load) begin
      hold_q  <= word;
      idx_q   <= '0;
      act_q   <= 1'b1;
      lastw_q <= last_word;
    end else if (act_q) begin
      if (end_byte) act_q <= 1'b0;
      idx_q <= idx_q + 2'd1;
    end
  end
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import capseq_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              abort,
  input  logic [CW-1:0]     read_cnt,
  input  logic [CW-1:0]     delay_cnt,
  input  logic [FLAG_W-1:0] flags,
  input  logic              trig,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rb_valid,
  output logic [GRP_W-1:0]  rb_byte,
  output logic              rb_last
);
  localparam int TW = CW + 4;
  localparam int PW = (AW > TW) ? AW : TW;

  seq_state_e        st_q, st_d;
  grp_cfg_t          cfg_in, cfg_q, cfg_d;
  logic              none_on;
  logic [CW-1:0]     rc_q, rc_d, dc_q, dc_d, post_q, post_d;
  logic [PW-1:0]     left_q, left_d, total_w;
  logic [AW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic              take, pk_clr, fire, unit_done, finish, load, word_done;
  logic [WORD_W-1:0] pk_word;
  logic              we_q;
  logic [AW-1:0]     waddr_q;
  logic [WORD_W-1:0] wdata_q;

  capseq_grp_decode u_dec (
    .flags   (flags),
    .cfg     (cfg_in),
    .none_on (none_on)
  );

  assign take = ((st_q == SQ_PRE) || (st_q == SQ_POST)) && smp_valid && !abort;

  capseq_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pk_clr),
    .take      (take),
    .data      (smp_data),
    .cfg       (cfg_q),
    .fire      (fire),
    .unit_done (unit_done),
    .word      (pk_word)
  );

  capseq_byte_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (abort),
    .load      (load),
    .word      (mem_rdata),
    .last_word (left_q == PW'(1)),
    .nemit     (cfg_q.nemit),
    .rb_valid  (rb_valid),
    .rb_byte   (rb_byte),
    .rb_last   (rb_last),
    .word_done (word_done)
  );

  assign total_w = (PW'(rc_q) + PW'(1)) << cfg_q.wlog;

  always_comb begin
    st_d   = st_q;
    cfg_d  = cfg_q;
    rc_d   = rc_q;
    dc_d   = dc_q;
    post_d = post_q;
    left_d = left_q;
    rptr_d = rptr_q;
    wptr_d = fire ? wptr_q + AW'(1) : wptr_q;
    pk_clr = 1'b0;
    finish = 1'b0;
    load   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (arm && !none_on) begin
          st_d   = SQ_PRE;
          cfg_d  = cfg_in;
          rc_d   = read_cnt;
          dc_d   = delay_cnt;
          wptr_d = '0;
          pk_clr = 1'b1;
        end
      end
      SQ_PRE: begin
        if (trig) begin
          if (unit_done && dc_q == '0) begin
            finish = 1'b1;
          end else begin
            st_d   = SQ_POST;
            post_d = unit_done ? dc_q - CW'(1) : dc_q;
          end
        end
      end
      SQ_POST: begin
        if (unit_done) begin
          if (post_q == '0) finish = 1'b1;
          else post_d = post_q - CW'(1);
        end
      end
      SQ_RREQ:  st_d = SQ_RWAIT;
      SQ_RWAIT: begin
        load = 1'b1;
        st_d = SQ_EMIT;
      end
      SQ_EMIT: begin
        if (word_done) begin
          if (left_q == PW'(1)) begin
            st_d = SQ_IDLE;
          end else begin
            left_d = left_q - PW'(1);
            rptr_d = rptr_q + AW'(1);
            st_d   = SQ_RREQ;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
    if (finish) begin
      st_d   = SQ_RREQ;
      left_d = total_w;
      rptr_d = wptr_q + AW'(1) - total_w[AW-1:0];
    end
    if (abort) begin
      st_d   = SQ_IDLE;
      pk_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cfg_q  <= '0;
      rc_q   <= '0;
      dc_q   <= '0;
      post_q <= '0;
      left_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      rc_q   <= rc_d;
      dc_q   <= dc_d;
      post_q <= post_d;
      left_q <= left_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= fire;
      if (fire) begin
        waddr_q <= wptr_q;
        wdata_q <= pk_word;
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
  assign mem_re    = (st_q == SQ_RREQ);
  assign mem_raddr = rptr_q;
endmodule

// File: rtl/capture_sequencer_chk.sv
module capture_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic abort,
  input logic smp_valid,
  input logic mem_we,
  input logic mem_re,
  input logic rb_valid,
  input logic rb_last
);
  assert_last_has_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rb_last |-> rb_valid);

  assert_read_not_during_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && rb_valid));

  assert_single_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!mem_we && !mem_re && !rb_valid));

  assert_write_from_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(smp_valid));

  assert_quiet_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rb_last |=> !rb_valid);
endmodule

bind capture_sequencer capture_sequencer_chk u_chk (.*);

// File: tb/capture_sequencer_bench.sv
`timescale 1ns/1ps
module capture_sequencer_bench;
  localparam int AW = 5;
  localparam int CW = 16;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [5:0] fl;
    logic [7:0] rc;
    logic [7:0] dc;
    logic [7:0] tix;
  } vec_t;

  // flags, read count-1, delay count-1, trigger sample index
  localparam vec_t VECS [0:5] = '{
    '{6'h00, 8'd3, 8'd1, 8'd8},
    '{6'h38, 8'd5, 8'd2, 8'd12},
    '{6'h14, 8'd4, 8'd0, 8'd20},
    '{6'h20, 8'd2, 8'd1, 8'd4},
    '{6'h19, 8'd2, 8'd1, 8'd8},
    '{6'h00, 8'd3, 8'd2, 8'd40}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic arm, abort, trig, smp_valid;
  logic [CW-1:0] read_cnt, delay_cnt;
  logic [5:0] flags;
  logic [31:0] smp_data;
  logic mem_we, mem_re, rb_valid, rb_last;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] rb_byte;

  logic [31:0] mem [0:DEPTH-1];
  logic [7:0] rb_buf [0:1023];
  logic [7:0] exp_buf [0:1023];
  int rb_n, wr_cnt, last_at, exp_n;
  bit seen_last;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  capture_sequencer #(.AW(AW), .CW(CW)) u_capture_sequencer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort),
    .read_cnt(read_cnt), .delay_cnt(delay_cnt), .flags(flags),
    .trig(trig), .smp_valid(smp_valid), .smp_data(smp_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .rb_valid(rb_valid), .rb_byte(rb_byte), .rb_last(rb_last)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_raddr];
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (mem_we) wr_cnt++;
      if (rb_valid) begin
        if (rb_n < 1024) rb_buf[rb_n] = rb_byte;
        if (rb_last) begin
          last_at = rb_n;
          seen_last = 1'b1;
        end
        rb_n++;
      end
    end
  end

  function automatic logic [7:0] sbyte(int s, int g);
    return 8'((s * 4 + g) ^ 'h5A);
  endfunction

  function automatic logic [3:0] en_of(logic [5:0] fl);
    logic [3:0] d;
    d = fl[5:2];
    if (fl[0]) d[3:2] = d[1:0];
    return ~d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_obs();
    wr_cnt = 0; rb_n = 0; last_at = -1; seen_last = 1'b0;
  endtask

  task automatic build_exp(input logic [5:0] fl, input int rc, input int endx);
    int spu, first;
    logic [3:0] en;
    en = en_of(fl);
    spu = fl[0] ? 8 : 4;
    first = endx - (rc + 1) * spu + 1;
    exp_n = 0;
    for (int s = first; s <= endx; s++) begin
      for (int g = 0; g < 4; g++) begin
        if (s < 0) begin
          exp_buf[exp_n] = 8'hEE; exp_n++;
        end else if (en[g]) begin
          exp_buf[exp_n] = sbyte(s, g); exp_n++;
        end
      end
    end
  endtask

  task automatic run_capture(input logic [5:0] fl, input int rc, input int dc,
                             input int tix, output int endx);
    int spu, nsamp;
    spu = fl[0] ? 8 : 4;
    endx = tix + (dc + 1) * spu - 1;
    nsamp = endx + 1 + 8;
    @(negedge clk);
    clear_obs();
    flags = fl; read_cnt = CW'(rc); delay_cnt = CW'(dc); arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int i = 0; i < nsamp; i++) begin
      smp_valid = 1'b1;
      smp_data = {sbyte(i, 3), sbyte(i, 2), sbyte(i, 1), sbyte(i, 0)};
      trig = (i == tix);
      @(negedge clk);
    end
    smp_valid = 1'b0; trig = 1'b0;
    for (int w = 0; w < 4000 && !seen_last; w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_stream(input string req);
    int mism, first_a, first_e;
    mism = 0; first_a = 0; first_e = 0;
    for (int k = 0; k < exp_n && k < rb_n; k++) begin
      if (rb_buf[k] !== exp_buf[k]) begin
        if (mism == 0) begin first_a = rb_buf[k]; first_e = exp_buf[k]; end
        mism++;
      end
    end
    chk(mism == 0, req, first_a, first_e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int endx, ng, bw;
    rst_n = 1'b0; arm = 1'b0; abort = 1'b0; trig = 1'b0; smp_valid = 1'b0;
    read_cnt = '0; delay_cnt = '0; flags = '0; smp_data = '0;
    clear_obs();
    repeat (3) @(negedge clk);
    chk({mem_we, mem_re, rb_valid, rb_last} == 4'b0, "R1 in reset",
        int'({mem_we, mem_re, rb_valid, rb_last}), 0);
    rst_n = 1'b1;
    trig = 1'b1; smp_valid = 1'b1;
    repeat (4) @(negedge clk);
    trig = 1'b0; smp_valid = 1'b0;
    chk(wr_cnt == 0 && rb_n == 0 && !mem_re && !rb_valid, "R1 idle after reset",
        wr_cnt + rb_n, 0);

    for (int vi = 0; vi < 6; vi++) begin
      string tag;
      tag = (vi == 4) ? "R7 demux content" : ((vi == 5) ? "R4 wrapped content" : "R5 content");
      run_capture(VECS[vi].fl, int'(VECS[vi].rc), int'(VECS[vi].dc), int'(VECS[vi].tix), endx);
      build_exp(VECS[vi].fl, int'(VECS[vi].rc), endx);
      ng = $countones(en_of(VECS[vi].fl));
      bw = (ng == 3) ? 4 : ng;
      chk(wr_cnt == (endx + 1) * bw / 4, "R3 R6 write count", wr_cnt, (endx + 1) * bw / 4);
      chk(rb_n == exp_n, "R2 readback length", rb_n, exp_n);
      compare_stream(tag);
      chk(seen_last && last_at == exp_n - 1, "R11 last marker", last_at, exp_n - 1);
    end

    // early trigger: stale words precede the stored ones
    @(negedge clk);
    for (int k = 0; k < DEPTH; k++) mem[k] <= 32'hEEEE_EEEE;
    run_capture(6'h00, 3, 0, 0, endx);
    build_exp(6'h00, 3, endx);
    chk(rb_n == exp_n, "R8 stale readback length", rb_n, exp_n);
    compare_stream("R8 stale content");

    // abort during pre-trigger phase
    @(negedge clk);
    flags = 6'h00; read_cnt = 16'd3; delay_cnt = 16'd1; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int i = 0; i < 6; i++) begin
      smp_valid = 1'b1; smp_data = {4{8'(i)}};
      @(negedge clk);
    end
    smp_valid = 1'b0; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    clear_obs();
    for (int i = 0; i < 40; i++) begin
      smp_valid = 1'b1; trig = (i == 4); smp_data = {4{8'(i)}};
      @(negedge clk);
    end
    smp_valid = 1'b0; trig = 1'b0;
    repeat (40) @(negedge clk);
    chk(wr_cnt == 0, "R9 no writes after abort", wr_cnt, 0);
    chk(rb_n == 0, "R9 no readback after abort", rb_n, 0);
    run_capture(VECS[0].fl, int'(VECS[0].rc), int'(VECS[0].dc), int'(VECS[0].tix), endx);
    build_exp(VECS[0].fl, int'(VECS[0].rc), endx);
    chk(rb_n == exp_n, "R9 capture after abort", rb_n, exp_n);
    compare_stream("R9 content after abort");

    // all groups disabled: arm ignored
    @(negedge clk);
    clear_obs();
    flags = 6'h3C; read_cnt = 16'd1; delay_cnt = 16'd0; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int i = 0; i < 40; i++) begin
      smp_valid = 1'b1; trig = (i == 8); smp_data = {4{8'(i)}};
      @(negedge clk);
    end
    smp_valid = 1'b0; trig = 1'b0;
    repeat (40) @(negedge clk);
    chk(wr_cnt == 0, "R10 no writes when all disabled", wr_cnt, 0);
    chk(rb_n == 0, "R10 no readback when all disabled", rb_n, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule